// File: doc/BRIEF.md
# Host Bridge Memory Window Control

This block is the register bank and address translator that sits between a system bus and the memory side of a PCI host bridge. Software programs eight 32-bit registers through a simple word-wide register port. Three of them steer the three inbound memory windows. The remaining five are a self identifier, a flags word and three secondary mapping words, which are stored and read back only.

A separate translation port takes a window index and a byte offset within that window. One cycle later it returns the PCI address that the access reaches, or marks the access out of range. The bridge is built in one of two variants, chosen by a parameter. In the primary variant, the low nibble of a mapping register supplies PCI address bits 31:28. In the alternate variant, the mapping register itself is the base, with every bit below the window's power-of-two size cleared. The two variants also use different window sizes.

Top module: `hbwin_ctrl`

## Requirements
- R1: After a cycle with `rst` high, all eight registers read back as zero.
- R2: A full-word write (`reg_be` = 4'hF) to a listed offset stores all 32 bits, and a later read of the same offset returns them. The offsets are: 0x00, 0x04 and 0x08 for the window mappings of windows 0, 1 and 2; 0x0C for the self identifier; 0x10 for the flags; 0x14, 0x18 and 0x1C for the three secondary mappings.
- R3: An access to any other offset, including a misaligned one or one above 0x1C, raises `reg_err`. A write of this kind changes no register. A read of this kind returns zero.
- R4: An access whose `reg_be` is not 4'hF is invalid. It raises `reg_err`, writes nothing and reads as zero.
- R5: Read data and `reg_rvalid` appear in the cycle after the read request. `reg_err` appears in the cycle after any access.
- R6: Primary variant (`ALT_MODE` = 0). The window base is bits 3:0 of the window's mapping register, placed at bits 31:28. The PCI address is the base OR the offset.
- R7: Alternate variant (`ALT_MODE` = 1). The window base is the mapping register with all bits below the window size cleared. The PCI address is the base OR the offset.
- R8: The window sizes are 0x0C000000, 0x10000000 and 0x10000000 in the primary variant, and 0x01000000, 0x04000000 and 0x08000000 in the alternate variant. An offset at or beyond the size sets `xl_range_err`, clears `xl_hit` and drives `xl_addr` to zero.
- R9: A translation request for window index 3 is out of range.
- R10: The translation result, with `xl_valid`, appears in the cycle after the request. A mapping write in the same cycle as a request does not affect that request, but it does affect the next request.
- R11: Writes to the self identifier, the flags and the secondary mapping registers do not change any translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset in the register region |
| reg_be | input | 4 | Byte enables; only 4'hF is valid |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Read data valid |
| reg_err | output | 1 | The previous access was invalid |
| xl_req | input | 1 | Translation request |
| xl_win | input | 2 | Window index |
| xl_offset | input | 32 | Byte offset inside the window |
| xl_valid | output | 1 | Translation result valid |
| xl_hit | output | 1 | The offset lies inside the window |
| xl_range_err | output | 1 | The offset or window index is out of range |
| xl_addr | output | 32 | Translated PCI address, zero on a miss |

## Verification
A mapping register write and a translation request for the same window can arrive in the same clock cycle. Which of the two takes effect first decides whether the old or the new base is used. The bench first programs a known old base. It then issues the write and the request on one edge, and expects the result to be built from the old base. A second request, issued on the following cycle, must then show the new base. Both variants receive the same stimulus, and each is compared with its own reference computation.

// File: rtl/hbwin_pkg.sv
package hbwin_pkg;

    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int REG_AW     = 12;
    localparam int NUM_WIN    = 3;
    localparam int NUM_REGS   = 8;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int WIN_IDX_W  = 2;
    localparam int NIBBLE_POS = DATA_W - 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [IDX_W-1:0] {
        RI_MAP0  = 3'd0,
        RI_MAP1  = 3'd1,
        RI_MAP2  = 3'd2,
        RI_IDENT = 3'd3,
        RI_FLAGS = 3'd4,
        RI_SEC0  = 3'd5,
        RI_SEC1  = 3'd6,
        RI_SEC2  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic     ok;
        reg_idx_e idx;
    } reg_dec_t;

    typedef struct packed {
        logic  hit;
        logic  miss;
        word_t addr;
    } xl_res_t;

    // Size of window idx for the selected variant.
    function automatic word_t win_size(input bit alt, input int idx);
        word_t sz;
        if (alt) begin
            case (idx)
                0:       sz = 32'h0100_0000;
                1:       sz = 32'h0400_0000;
                default: sz = 32'h0800_0000;
            endcase
        end else begin
            case (idx)
                0:       sz = 32'h0C00_0000;
                default: sz = 32'h1000_0000;
            endcase
        end
        return sz;
    endfunction

    // Register offset decode: word aligned, inside the eight-word block.
    function automatic reg_dec_t decode(input logic [REG_AW-1:0] a);
        reg_dec_t d;
        d.ok  = (a[1:0] == 2'b00) && (a[REG_AW-1:IDX_W+2] == '0);
        d.idx = reg_idx_e'(a[IDX_W+1:2]);
        return d;
    endfunction

endpackage

// File: rtl/hbwin_regfile.sv
module hbwin_regfile
    import hbwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  word_t             wdata,
    output word_t             rdata,
    output logic              rvalid,
    output logic              err,
    output word_t             map_o [NUM_WIN]
);

    reg_dec_t dec;
    logic     acc_ok;
    logic     wr_ok;
    word_t    regs_q [NUM_REGS];
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    assign dec    = decode(addr);
    assign acc_ok = dec.ok && (be == {BE_W{1'b1}});
    assign wr_ok  = en && we && acc_ok;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr_ok && (dec.idx == reg_idx_e'(i))) begin
                regs_q[i] <= wdata;
            end
        end
        assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_map_out
        assign map_o[w] = regs_q[w];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            rvalid <= en && !we;
            err    <= en && !acc_ok;
            if (en && !we) begin
                rdata <= acc_ok ? regs_q[dec.idx] : '0;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (regs_flat == '0));  // R1

    AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (en && we && !acc_ok) |=> $stable(regs_flat));  // R3

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rvalid && err) |-> (rdata == '0));  // R4

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (en && !we) |=> rvalid);  // R5

endmodule

// File: rtl/hbwin_winbase.sv
module hbwin_winbase
    import hbwin_pkg::*;
#(
    parameter bit ALT_MODE = 1'b0,
    parameter int WIN_IDX  = 0
) (
    input  word_t map_i,
    output word_t base_o,
    output word_t size_o
);

    localparam word_t SIZE = win_size(ALT_MODE, WIN_IDX);

    assign size_o = SIZE;

    if (ALT_MODE) begin : g_alt
        assign base_o = map_i & ~(SIZE - 32'd1);
    end else begin : g_pri
        assign base_o = {map_i[3:0], {NIBBLE_POS{1'b0}}};
    end

endmodule

// File: rtl/hbwin_xlate.sv
module hbwin_xlate
    import hbwin_pkg::*;
#(
    parameter bit ALT_MODE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [WIN_IDX_W-1:0] win,
    input  word_t                offset,
    input  word_t                map_i [NUM_WIN],
    output logic                 valid,
    output xl_res_t              res
);

    word_t   base_w [NUM_WIN];
    word_t   size_w [NUM_WIN];
    xl_res_t nxt;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        hbwin_winbase #(
            .ALT_MODE (ALT_MODE),
            .WIN_IDX  (w)
        ) u_base (
            .map_i  (map_i[w]),
            .base_o (base_w[w]),
            .size_o (size_w[w])
        );
    end

    always_comb begin
        nxt = '0;
        if (req) begin
            if ((int'(win) < NUM_WIN) && (offset < size_w[win])) begin
                nxt.hit  = 1'b1;
                nxt.addr = base_w[win] | offset;
            end else begin
                nxt.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            res   <= '0;
        end else begin
            valid <= req;
            res   <= nxt;
        end
    end

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(res.hit && res.miss));  // R8

    AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        res.miss |-> (res.addr == '0));  // R8

    AST_BAD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (req && (int'(win) >= NUM_WIN)) |=> (valid && res.miss));  // R9

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req |=> (valid && (res.hit || res.miss)));  // R10

endmodule

// File: rtl/hbwin_ctrl.sv
module hbwin_ctrl
    import hbwin_pkg::*;
#(
    parameter bit ALT_MODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    output logic        reg_err,
    input  logic        xl_req,
    input  logic [1:0]  xl_win,
    input  logic [31:0] xl_offset,
    output logic        xl_valid,
    output logic        xl_hit,
    output logic        xl_range_err,
    output logic [31:0] xl_addr
);

    word_t   map_w [NUM_WIN];
    xl_res_t res;

    hbwin_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .en     (reg_en),
        .we     (reg_we),
        .addr   (reg_addr),
        .be     (reg_be),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .rvalid (reg_rvalid),
        .err    (reg_err),
        .map_o  (map_w)
    );

    hbwin_xlate #(
        .ALT_MODE (ALT_MODE)
    ) u_xlate (
        .clk    (clk),
        .rst    (rst),
        .req    (xl_req),
        .win    (xl_win),
        .offset (xl_offset),
        .map_i  (map_w),
        .valid  (xl_valid),
        .res    (res)
    );

    assign xl_hit       = res.hit;
    assign xl_range_err = res.miss;
    assign xl_addr      = res.addr;

endmodule

// File: tb/hbwin_ctrl_tb.sv
module hbwin_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic        xl_req = 1'b0;
    logic [1:0]  xl_win = '0;
    logic [31:0] xl_offset = '0;

    logic [31:0] p_rdata, a_rdata, p_addr, a_addr;
    logic        p_rvalid, a_rvalid, p_err, a_err;
    logic        p_xv, a_xv, p_hit, a_hit, p_rerr, a_rerr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hbwin_ctrl #(.ALT_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(p_rdata), .reg_rvalid(p_rvalid), .reg_err(p_err),
        .xl_req(xl_req), .xl_win(xl_win), .xl_offset(xl_offset),
        .xl_valid(p_xv), .xl_hit(p_hit), .xl_range_err(p_rerr), .xl_addr(p_addr)
    );

    hbwin_ctrl #(.ALT_MODE(1'b1)) u_dut_alt (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(a_rdata), .reg_rvalid(a_rvalid), .reg_err(a_err),
        .xl_req(xl_req), .xl_win(xl_win), .xl_offset(xl_offset),
        .xl_valid(a_xv), .xl_hit(a_hit), .xl_range_err(a_rerr), .xl_addr(a_addr)
    );

    typedef struct packed {
        logic [1:0]  win;
        logic [31:0] map;
        logic [31:0] off;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h0000_0005, 32'h0123_4560},
        '{2'd1, 32'hFFFF_FFFF, 32'h0FFF_FFFC},
        '{2'd2, 32'h1234_5678, 32'h07FF_FFFF},
        '{2'd0, 32'h0000_000A, 32'h0BFF_FFFF},
        '{2'd0, 32'h0000_000A, 32'h0C00_0000},
        '{2'd1, 32'h8765_4321, 32'h03FF_FFFF},
        '{2'd2, 32'h0000_0003, 32'h1000_0000},
        '{2'd0, 32'hFFFF_FFF0, 32'h00FF_FFFF},
        '{2'd3, 32'h0000_0000, 32'h0000_0010}
    };

    logic [31:0] cur_map [3] = '{32'h0, 32'h0, 32'h0};

    function automatic logic [31:0] ref_size(input bit alt, input int w);
        if (alt) return (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
        return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    endfunction

    // Returns {hit, addr}; window 3 or offset past the size is a miss.
    function automatic logic [32:0] ref_xl(input bit alt, input int w,
                                           input logic [31:0] m, input logic [31:0] o);
        logic [31:0] base;
        if (w > 2 || o >= ref_size(alt, w)) return 33'd0;
        if (alt) base = m & ~(ref_size(alt, w) - 32'd1);
        else     base = {m[3:0], 28'd0};
        return {1'b1, base | o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_acc(input logic we, input logic [11:0] a, input logic [3:0] be,
                           input logic [31:0] d);
        reg_en = 1'b1; reg_we = we; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic xl(input logic [1:0] w, input logic [31:0] o);
        xl_req = 1'b1; xl_win = w; xl_offset = o;
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    task automatic check_xl(input string req, input int w, input logic [31:0] o);
        logic [32:0] ep, ea;
        ep = ref_xl(1'b0, w, cur_map[w > 2 ? 0 : w], o);
        ea = ref_xl(1'b1, w, cur_map[w > 2 ? 0 : w], o);
        check(req, {31'd0, p_xv}, 32'd1);
        check(req, {31'd0, p_hit}, {31'd0, ep[32]});
        check(req, {31'd0, p_rerr}, {31'd0, ~ep[32]});
        check(req, p_addr, ep[31:0]);
        check(req, {31'd0, a_hit}, {31'd0, ea[32]});
        check(req, {31'd0, a_rerr}, {31'd0, ~ea[32]});
        check(req, a_addr, ea[31:0]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) begin
            reg_acc(1'b0, 12'(i * 4), 4'hF, 32'h0);
            check("R1", p_rdata, 32'h0);
            check("R1", a_rdata, 32'h0);
        end

        // R2, R5: full-word writes and readback at every listed offset
        for (int i = 0; i < 8; i++) begin
            reg_acc(1'b1, 12'(i * 4), 4'hF, 32'hC0DE_0000 + 32'(i * 32'h1111));
        end
        for (int i = 0; i < 8; i++) begin
            reg_acc(1'b0, 12'(i * 4), 4'hF, 32'h0);
            check("R5", {31'd0, p_rvalid}, 32'd1);
            check("R2", p_rdata, 32'hC0DE_0000 + 32'(i * 32'h1111));
            check("R2", {31'd0, p_err}, 32'd0);
        end
        for (int i = 0; i < 3; i++) cur_map[i] = 32'hC0DE_0000 + 32'(i * 32'h1111);

        // R3: unlisted offsets
        reg_acc(1'b1, 12'h020, 4'hF, 32'hDEAD_BEEF);
        check("R3", {31'd0, p_err}, 32'd1);
        reg_acc(1'b1, 12'h002, 4'hF, 32'hDEAD_BEEF);
        check("R3", {31'd0, p_err}, 32'd1);
        reg_acc(1'b0, 12'h020, 4'hF, 32'h0);
        check("R3", p_rdata, 32'h0);
        check("R3", {31'd0, a_err}, 32'd1);
        reg_acc(1'b0, 12'h000, 4'hF, 32'h0);
        check("R3", p_rdata, cur_map[0]);

        // R4: partial byte enables
        reg_acc(1'b1, 12'h004, 4'h3, 32'h1234_5678);
        check("R4", {31'd0, p_err}, 32'd1);
        reg_acc(1'b0, 12'h004, 4'h1, 32'h0);
        check("R4", p_rdata, 32'h0);
        check("R4", {31'd0, p_err}, 32'd1);
        reg_acc(1'b0, 12'h004, 4'hF, 32'h0);
        check("R4", p_rdata, cur_map[1]);

        // R6, R7, R8, R9: vector table
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].win < 2'd3) begin
                reg_acc(1'b1, {8'd0, VECS[v].win, 2'b00}, 4'hF, VECS[v].map);
                cur_map[VECS[v].win] = VECS[v].map;
            end
            xl(VECS[v].win, VECS[v].off);
            check_xl((VECS[v].win == 2'd3) ? "R9" : "R6/R7/R8 vec", int'(VECS[v].win), VECS[v].off);
        end

        // R10: mapping write and translation in the same cycle
        reg_acc(1'b1, 12'h004, 4'hF, 32'h0C00_0007);
        cur_map[1] = 32'h0C00_0007;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 12'h004; reg_be = 4'hF;
        reg_wdata = 32'h0800_0002;
        xl_req = 1'b1; xl_win = 2'd1; xl_offset = 32'h0000_0010;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; xl_req = 1'b0;
        check_xl("R10 old", 1, 32'h0000_0010);
        cur_map[1] = 32'h0800_0002;
        xl(2'd1, 32'h0000_0010);
        check_xl("R10 new", 1, 32'h0000_0010);

        // R11: self id, flags and secondary writes leave translation alone
        for (int i = 3; i < 8; i++) reg_acc(1'b1, 12'(i * 4), 4'hF, 32'hFFFF_FFFF);
        for (int w = 0; w < 3; w++) begin
            xl(2'(w), 32'h0000_1000);
            check_xl("R11", w, 32'h0000_1000);
        end

        // R1: reset again clears registers and translation bases
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) cur_map[i] = 32'h0;
        reg_acc(1'b0, 12'h010, 4'hF, 32'h0);
        check("R1", p_rdata, 32'h0);
        xl(2'd2, 32'h0000_0040);
        check_xl("R1", 2, 32'h0000_0040);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule